// File: doc/BRIEF.md
# ECC Error Capture and Report Unit

This block sits beside a memory read path and listens to its ECC outcome pulses: one pulse type for a single-bit error that was corrected, one for a double-bit error that could only be detected. With every pulse the read path presents the failing address, a bank indicator, and area indicators for the system area, the one-time-programmable (OTP) area and the narrow-ECC data area. The unit keeps one report register for corrected errors and one for detected errors. Each report register records only the first failing location and then holds it until software clears its flag. For detected errors, a companion register also keeps the failing data word when the error lies in an area protected with narrow ECC.

The unit drives a maskable interrupt while a correction is recorded and its enable is set. It drives a non-maskable event while a detection is recorded. Software reads the three registers through a small select-based port, sets the correction interrupt enable, and clears each flag by writing 1 to it. Clearing a flag also zeroes the address and attributes that were captured with it.

Top module: `ecc_err_capture`

## Requirements
- R1: After a synchronous reset, all three registers read 0 and both `corr_irq` and `det_nmi` are low.
- R2: A `sec_hit` pulse while the correction flag is clear records the event in the correction register: address in bits 15:0, bank in bit 22, system-area flag in bit 23, OTP flag in bit 24, correction flag in bit 30. It is readable through select 0.
- R3: A `ded_hit` pulse while the detection flag is clear records the event in the detection register (select 1) with the same address and attribute layout, and the detection flag in bit 31.
- R4: While a flag is set, further pulses of that type do not change the recorded address or attributes.
- R5: Writing 1 to the flag bit (bit 30 at select 0, bit 31 at select 1) clears the flag and zeroes the address and attribute bits. Writing 0 to the flag bit leaves the register unchanged.
- R6: Bit 25 at select 0 is the correction interrupt enable. It is written with every select-0 write and reads back, and clearing the flag does not change it. Writes to select 1 affect no bit other than the flag clear. Writes to select 2 change nothing.
- R7: `corr_irq` is high exactly when the correction flag and the enable are both set, and it changes on the same clock edge as they do.
- R8: `det_nmi` is high exactly when the detection flag is set, whatever the enable is, and it changes on the same edge as the flag.
- R9: Select 2 returns the `hit_data` word that arrived with the recorded detection when that event had `hit_darea` or `hit_otp` set. Otherwise it returns 0. It is cleared together with the detection flag.
- R10: A `sec_hit` and a `ded_hit` in the same cycle are both captured, each into its own register.
- R11: When a flag-clear write and a new pulse of the same type share a cycle, the new event is captured and the flag stays set.
- R12: `reg_rdata` is registered. The select presented before an edge returns, after that edge, the register state from before that edge. Select 3 returns 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| sec_hit | input | 1 | Single-bit error corrected on this read |
| ded_hit | input | 1 | Double-bit error detected on this read |
| hit_addr | input | AW | Failing address |
| hit_bank | input | 1 | Bank of the failing read |
| hit_sys | input | 1 | Read was in the system area |
| hit_otp | input | 1 | Read was in the OTP area |
| hit_darea | input | 1 | Read was in the narrow-ECC data area |
| hit_data | input | DW | Raw data word of the failing read |
| reg_wr | input | 1 | Register write strobe |
| reg_sel | input | 2 | Register select: 0 correction, 1 detection, 2 data, 3 none |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Registered read data |
| corr_irq | output | 1 | Maskable correction interrupt (level) |
| det_nmi | output | 1 | Non-maskable detection event (level) |

## Verification
A pulse or write presented before an edge shows up in the flags, `corr_irq` and `det_nmi` right after that edge. A register read shows it one edge later, because the read port adds its own register. The bench therefore drives every input on a falling edge and samples the outputs on the next falling edge. Reads present the select, wait through one rising edge and sample on the following falling edge. The bench sweeps every combination of the bank, system, OTP and data-area bits at computed addresses, with both pulse types arriving together. It repeats the pulses to confirm the first capture is held, and it covers clears, no-effect writes and a clear that coincides with a new pulse.

// File: rtl/ecc_cap_pkg.sv
package ecc_cap_pkg;
  localparam int WORD_W    = 32;
  localparam int BANK_BIT  = 22;
  localparam int SYS_BIT   = 23;
  localparam int OTP_BIT   = 24;
  localparam int CIE_BIT   = 25;
  localparam int CFLAG_BIT = 30;
  localparam int DFLAG_BIT = 31;
  localparam int ADDR_MAX  = 22;

  typedef enum logic [1:0] {
    SEL_CORR = 2'd0,
    SEL_DET  = 2'd1,
    SEL_DATA = 2'd2,
    SEL_NONE = 2'd3
  } sel_e;
endpackage

// File: rtl/ecc_cap_slot.sv
// One capture register: first-event hold, clear-to-zero, optional enable
// and optional data word, plus a registered level event.
module ecc_cap_slot #(
  parameter int AW       = 16,
  parameter int DW       = 16,
  parameter bit HAS_EN   = 1'b0,
  parameter bit HAS_DATA = 1'b0
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          hit,
  input  logic          clr,
  input  logic [AW-1:0] in_addr,
  input  logic          in_bank,
  input  logic          in_sys,
  input  logic          in_otp,
  input  logic          data_ok,
  input  logic [DW-1:0] in_data,
  input  logic          en_we,
  input  logic          en_wv,
  output logic          flag_q,
  output logic          en_q,
  output logic [AW-1:0] addr_q,
  output logic          bank_q,
  output logic          sys_q,
  output logic          otp_q,
  output logic [DW-1:0] data_q,
  output logic          evt_q
);
  logic take;
  logic flag_d;
  logic gate_d;

  // capture only into an empty slot, or one being cleared this cycle
  assign take   = hit & (~flag_q | clr);
  assign flag_d = take | (flag_q & ~clr);

  always_ff @(posedge clk) begin
    if (rst) begin
      flag_q <= 1'b0;
      addr_q <= '0;
      bank_q <= 1'b0;
      sys_q  <= 1'b0;
      otp_q  <= 1'b0;
    end else begin
      flag_q <= flag_d;
      if (take) begin
        addr_q <= in_addr;
        bank_q <= in_bank;
        sys_q  <= in_sys;
        otp_q  <= in_otp;
      end else if (clr) begin
        addr_q <= '0;
        bank_q <= 1'b0;
        sys_q  <= 1'b0;
        otp_q  <= 1'b0;
      end
    end
  end

  generate
    if (HAS_EN) begin : g_en
      logic en_d;
      assign en_d   = en_we ? en_wv : en_q;
      assign gate_d = en_d;
      always_ff @(posedge clk) begin
        if (rst) en_q <= 1'b0;
        else     en_q <= en_d;
      end
    end else begin : g_no_en
      logic unused_en;
      assign unused_en = en_we ^ en_wv;
      assign gate_d    = 1'b1;
      assign en_q      = 1'b0;
    end

    if (HAS_DATA) begin : g_data
      always_ff @(posedge clk) begin
        if (rst)               data_q <= '0;
        else if (take)         data_q <= data_ok ? in_data : '0;
        else if (clr)          data_q <= '0;
      end
    end else begin : g_no_data
      logic unused_data;
      assign unused_data = data_ok ^ (^in_data);
      assign data_q      = '0;
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) evt_q <= 1'b0;
    else     evt_q <= flag_d & gate_d;
  end
endmodule

// File: rtl/ecc_cap_regif.sv
// Write decode (write-1-to-clear, enable) and registered read mux.
module ecc_cap_regif #(
  parameter int AW = 16,
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          reg_wr,
  input  logic [1:0]    reg_sel,
  input  logic [31:0]   reg_wdata,
  input  logic          c_flag,
  input  logic          c_en,
  input  logic [AW-1:0] c_addr,
  input  logic          c_bank,
  input  logic          c_sys,
  input  logic          c_otp,
  input  logic          d_flag,
  input  logic [AW-1:0] d_addr,
  input  logic          d_bank,
  input  logic          d_sys,
  input  logic          d_otp,
  input  logic [DW-1:0] d_data,
  output logic          clr_corr,
  output logic          clr_det,
  output logic          en_we,
  output logic          en_wv,
  output logic [31:0]   reg_rdata
);
  import ecc_cap_pkg::*;

  logic [WORD_W-1:0] corr_word;
  logic [WORD_W-1:0] det_word;
  logic [WORD_W-1:0] data_word;
  logic [WORD_W-1:0] rd_next;
  logic              sel_c;
  logic              sel_d;

  assign sel_c    = reg_wr & (sel_e'(reg_sel) == SEL_CORR);
  assign sel_d    = reg_wr & (sel_e'(reg_sel) == SEL_DET);
  assign clr_corr = sel_c & reg_wdata[CFLAG_BIT];
  assign clr_det  = sel_d & reg_wdata[DFLAG_BIT];
  assign en_we    = sel_c;
  assign en_wv    = reg_wdata[CIE_BIT];

  always_comb begin
    corr_word            = '0;
    corr_word[AW-1:0]    = c_addr;
    corr_word[BANK_BIT]  = c_bank;
    corr_word[SYS_BIT]   = c_sys;
    corr_word[OTP_BIT]   = c_otp;
    corr_word[CIE_BIT]   = c_en;
    corr_word[CFLAG_BIT] = c_flag;

    det_word             = '0;
    det_word[AW-1:0]     = d_addr;
    det_word[BANK_BIT]   = d_bank;
    det_word[SYS_BIT]    = d_sys;
    det_word[OTP_BIT]    = d_otp;
    det_word[DFLAG_BIT]  = d_flag;

    data_word            = '0;
    data_word[DW-1:0]    = d_data;

    unique case (sel_e'(reg_sel))
      SEL_CORR: rd_next = corr_word;
      SEL_DET:  rd_next = det_word;
      SEL_DATA: rd_next = data_word;
      default:  rd_next = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) reg_rdata <= '0;
    else     reg_rdata <= rd_next;
  end

  logic unused_wdata;
  assign unused_wdata = ^{reg_wdata[29:26], reg_wdata[24:0]};
endmodule

// File: rtl/ecc_err_capture.sv
module ecc_err_capture #(
  parameter int AW = 16,
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          sec_hit,
  input  logic          ded_hit,
  input  logic [AW-1:0] hit_addr,
  input  logic          hit_bank,
  input  logic          hit_sys,
  input  logic          hit_otp,
  input  logic          hit_darea,
  input  logic [DW-1:0] hit_data,
  input  logic          reg_wr,
  input  logic [1:0]    reg_sel,
  input  logic [31:0]   reg_wdata,
  output logic [31:0]   reg_rdata,
  output logic          corr_irq,
  output logic          det_nmi
);
  logic          clr_corr, clr_det, en_we, en_wv;
  logic          corr_flag, corr_en, corr_bank, corr_sys, corr_otp;
  logic [AW-1:0] corr_addr;
  logic [DW-1:0] corr_data_unused;
  logic          det_flag, det_en_unused, det_bank, det_sys, det_otp;
  logic [AW-1:0] det_addr;
  logic [DW-1:0] det_data;

  ecc_cap_slot #(.AW(AW), .DW(DW), .HAS_EN(1'b1), .HAS_DATA(1'b0)) u_corr (
    .clk(clk), .rst(rst), .hit(sec_hit), .clr(clr_corr),
    .in_addr(hit_addr), .in_bank(hit_bank), .in_sys(hit_sys), .in_otp(hit_otp),
    .data_ok(1'b0), .in_data(hit_data), .en_we(en_we), .en_wv(en_wv),
    .flag_q(corr_flag), .en_q(corr_en), .addr_q(corr_addr), .bank_q(corr_bank),
    .sys_q(corr_sys), .otp_q(corr_otp), .data_q(corr_data_unused), .evt_q(corr_irq)
  );

  ecc_cap_slot #(.AW(AW), .DW(DW), .HAS_EN(1'b0), .HAS_DATA(1'b1)) u_det (
    .clk(clk), .rst(rst), .hit(ded_hit), .clr(clr_det),
    .in_addr(hit_addr), .in_bank(hit_bank), .in_sys(hit_sys), .in_otp(hit_otp),
    .data_ok(hit_darea | hit_otp), .in_data(hit_data), .en_we(1'b0), .en_wv(1'b0),
    .flag_q(det_flag), .en_q(det_en_unused), .addr_q(det_addr), .bank_q(det_bank),
    .sys_q(det_sys), .otp_q(det_otp), .data_q(det_data), .evt_q(det_nmi)
  );

  ecc_cap_regif #(.AW(AW), .DW(DW)) u_regif (
    .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_sel(reg_sel), .reg_wdata(reg_wdata),
    .c_flag(corr_flag), .c_en(corr_en), .c_addr(corr_addr), .c_bank(corr_bank),
    .c_sys(corr_sys), .c_otp(corr_otp),
    .d_flag(det_flag), .d_addr(det_addr), .d_bank(det_bank), .d_sys(det_sys),
    .d_otp(det_otp), .d_data(det_data),
    .clr_corr(clr_corr), .clr_det(clr_det), .en_we(en_we), .en_wv(en_wv),
    .reg_rdata(reg_rdata)
  );
endmodule

// File: rtl/ecc_cap_checker.sv
module ecc_cap_checker #(
  parameter int AW = 16
) (
  input logic          clk,
  input logic          rst,
  input logic          sec_hit,
  input logic          ded_hit,
  input logic          clr_corr,
  input logic          clr_det,
  input logic          corr_flag,
  input logic          corr_en,
  input logic [AW-1:0] corr_addr,
  input logic          det_flag,
  input logic [AW-1:0] det_addr,
  input logic          corr_irq,
  input logic          det_nmi
);
  assert_reset_quiet_R1: assert property (@(posedge clk)
    rst |=> (!corr_irq && !det_nmi && !corr_flag && !det_flag));

  assert_corr_capture_R2: assert property (@(posedge clk) disable iff (rst)
    (sec_hit && !corr_flag) |=> corr_flag);

  assert_corr_hold_R4: assert property (@(posedge clk) disable iff (rst)
    (corr_flag && !clr_corr) |=> $stable(corr_addr));

  assert_det_hold_R4: assert property (@(posedge clk) disable iff (rst)
    (det_flag && !clr_det) |=> $stable(det_addr));

  assert_det_clear_R5: assert property (@(posedge clk) disable iff (rst)
    (clr_det && !ded_hit) |=> (det_addr == '0 && !det_flag && !det_nmi));

  assert_irq_gated_R7: assert property (@(posedge clk) disable iff (rst)
    corr_irq |-> (corr_en && corr_flag));

  assert_nmi_on_detect_R8: assert property (@(posedge clk) disable iff (rst)
    ded_hit |=> det_nmi);

  assert_clear_vs_hit_R11: assert property (@(posedge clk) disable iff (rst)
    (clr_corr && sec_hit) |=> corr_flag);
endmodule

bind ecc_err_capture ecc_cap_checker #(.AW(AW)) u_chk (
  .clk(clk), .rst(rst), .sec_hit(sec_hit), .ded_hit(ded_hit),
  .clr_corr(clr_corr), .clr_det(clr_det), .corr_flag(corr_flag),
  .corr_en(corr_en), .corr_addr(corr_addr), .det_flag(det_flag),
  .det_addr(det_addr), .corr_irq(corr_irq), .det_nmi(det_nmi)
);

// File: tb/ecc_err_capture_bench.sv
`timescale 1ns/1ps
module ecc_err_capture_bench;
  localparam int AW = 16;
  localparam int DW = 16;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          sec_hit = 1'b0, ded_hit = 1'b0;
  logic [AW-1:0] hit_addr = '0;
  logic          hit_bank = 1'b0, hit_sys = 1'b0, hit_otp = 1'b0, hit_darea = 1'b0;
  logic [DW-1:0] hit_data = '0;
  logic          reg_wr = 1'b0;
  logic [1:0]    reg_sel = 2'd3;
  logic [31:0]   reg_wdata = '0;
  logic [31:0]   reg_rdata;
  logic          corr_irq, det_nmi;

  int total = 0;
  int bad   = 0;
  bit done  = 1'b0;

  always #4 clk = ~clk;

  ecc_err_capture #(.AW(AW), .DW(DW)) u_ecc_err_capture (
    .clk(clk), .rst(rst), .sec_hit(sec_hit), .ded_hit(ded_hit),
    .hit_addr(hit_addr), .hit_bank(hit_bank), .hit_sys(hit_sys), .hit_otp(hit_otp),
    .hit_darea(hit_darea), .hit_data(hit_data), .reg_wr(reg_wr), .reg_sel(reg_sel),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .corr_irq(corr_irq), .det_nmi(det_nmi)
  );

  function automatic logic [31:0] rep_word(input int fbit, input logic f, input logic en,
                                           input logic otp, input logic sys,
                                           input logic bank, input logic [15:0] a);
    logic [31:0] w;
    w = 32'(a) | (32'(bank) << 22) | (32'(sys) << 23) | (32'(otp) << 24) | (32'(en) << 25);
    if (f) w = w | (32'd1 << fbit);
    else   w = 32'(en) << 25;
    return w;
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic rd(input logic [1:0] s, output logic [31:0] v);
    @(negedge clk);
    reg_sel = s;
    @(negedge clk);
    v = reg_rdata;
    reg_sel = 2'd3;
  endtask

  task automatic wr(input logic [1:0] s, input logic [31:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_sel = s; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0; reg_sel = 2'd3; reg_wdata = '0;
  endtask

  // pulses, optionally together with a register write in the same cycle
  task automatic hit(input logic s, input logic d, input logic [15:0] a, input logic [3:0] at,
                     input logic [15:0] dat, input logic w, input logic [1:0] ws,
                     input logic [31:0] wd);
    @(negedge clk);
    sec_hit = s; ded_hit = d; hit_addr = a;
    hit_bank = at[0]; hit_sys = at[1]; hit_otp = at[2]; hit_darea = at[3];
    hit_data = dat; reg_wr = w; reg_sel = ws; reg_wdata = wd;
    @(negedge clk);
    sec_hit = 0; ded_hit = 0; hit_addr = '0; hit_bank = 0; hit_sys = 0;
    hit_otp = 0; hit_darea = 0; hit_data = '0; reg_wr = 0; reg_sel = 2'd3; reg_wdata = '0;
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog act=timeout exp=finish");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin : main
    logic [31:0] v;
    logic [15:0] a, a2, dt;
    logic        en, dok;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R1 reset state
    rd(2'd0, v); check("R1 corr", v, 32'h0);
    rd(2'd1, v); check("R1 det",  v, 32'h0);
    rd(2'd2, v); check("R1 data", v, 32'h0);
    check("R1 irq", 32'(corr_irq), 32'h0);
    check("R1 nmi", 32'(det_nmi),  32'h0);

    for (int c = 0; c < 16; c++) begin
      a   = 16'((c * 4111 + 17) & 16'hFFFF);
      a2  = a ^ 16'h5A5A;
      dt  = ~a;
      en  = c[0] ^ c[2];
      dok = c[2] | c[3];
      wr(2'd0, 32'(en) << 25);
      // R10 both pulse types in one cycle
      hit(1'b1, 1'b1, a, 4'(c), dt, 1'b0, 2'd3, 32'h0);
      check("R7 irq", 32'(corr_irq), 32'(en));
      check("R8 nmi", 32'(det_nmi), 32'h1);
      rd(2'd0, v); check("R2 R10 corr", v, rep_word(30, 1, en, c[2], c[1], c[0], a));
      rd(2'd1, v); check("R3 R10 det",  v, rep_word(31, 1, 0,  c[2], c[1], c[0], a));
      rd(2'd2, v); check("R9 data", v, dok ? 32'(dt) : 32'h0);
      // R4 later pulses ignored
      hit(1'b1, 1'b1, a2, ~4'(c), ~dt, 1'b0, 2'd3, 32'h0);
      rd(2'd0, v); check("R4 corr", v, rep_word(30, 1, en, c[2], c[1], c[0], a));
      rd(2'd1, v); check("R4 det",  v, rep_word(31, 1, 0,  c[2], c[1], c[0], a));
      rd(2'd2, v); check("R4 data", v, dok ? 32'(dt) : 32'h0);
      // R5/R6 no-effect writes
      wr(2'd1, 32'h7FFF_FFFF);
      wr(2'd2, 32'hFFFF_FFFF);
      wr(2'd0, 32'(en) << 25);
      rd(2'd0, v); check("R5 corr kept", v, rep_word(30, 1, en, c[2], c[1], c[0], a));
      rd(2'd1, v); check("R6 det kept",  v, rep_word(31, 1, 0,  c[2], c[1], c[0], a));
      rd(2'd2, v); check("R6 data kept", v, dok ? 32'(dt) : 32'h0);
      rd(2'd3, v); check("R12 none", v, 32'h0);
      // R5 clears
      wr(2'd0, (32'(en) << 25) | (32'd1 << 30));
      check("R7 irq clr", 32'(corr_irq), 32'h0);
      wr(2'd1, 32'h8000_0000);
      check("R8 nmi clr", 32'(det_nmi), 32'h0);
      rd(2'd0, v); check("R5 R6 corr clr", v, 32'(en) << 25);
      rd(2'd1, v); check("R5 det clr", v, 32'h0);
      rd(2'd2, v); check("R9 data clr", v, 32'h0);
    end

    // R7 enable toggled while flag held
    wr(2'd0, 32'h0);
    hit(1'b1, 1'b0, 16'h1234, 4'b0001, 16'h0, 1'b0, 2'd3, 32'h0);
    check("R7 irq masked", 32'(corr_irq), 32'h0);
    wr(2'd0, 32'd1 << 25);
    check("R7 irq enabled", 32'(corr_irq), 32'h1);
    rd(2'd1, v); check("R10 det untouched", v, 32'h0);
    // R11 clear and new pulse in the same cycle
    hit(1'b1, 1'b0, 16'hBEEF, 4'b0110, 16'h0, 1'b1, 2'd0, (32'd1 << 30) | (32'd1 << 25));
    check("R11 irq", 32'(corr_irq), 32'h1);
    rd(2'd0, v); check("R11 corr", v, rep_word(30, 1, 1, 1, 1, 0, 16'hBEEF));
    hit(1'b0, 1'b1, 16'h0F0F, 4'b1000, 16'hCAFE, 1'b0, 2'd3, 32'h0);
    hit(1'b0, 1'b1, 16'h7777, 4'b0001, 16'h1111, 1'b1, 2'd1, 32'h8000_0000);
    rd(2'd1, v); check("R11 det", v, rep_word(31, 1, 0, 0, 0, 1, 16'h7777));
    rd(2'd2, v); check("R11 R9 data", v, 32'h0);
    check("R8 nmi held", 32'(det_nmi), 32'h1);
    // R12 read latency: value present one edge after the select
    @(negedge clk); reg_sel = 2'd0;
    @(posedge clk); #1;
    check("R12 latency", reg_rdata, rep_word(30, 1, 1, 1, 1, 0, 16'hBEEF));
    @(negedge clk); reg_sel = 2'd3;
    // R1 reset mid-run
    rst = 1'b1; @(negedge clk); rst = 1'b0;
    check("R1 irq rst", 32'(corr_irq), 32'h0);
    check("R1 nmi rst", 32'(det_nmi), 32'h0);
    rd(2'd0, v); check("R1 corr rst", v, 32'h0);

    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule